// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which of eleven interrupt sources the core should service next. Seven active-low external lines pass through a synchronizer, and six internal event pulses arrive already in the clock domain. The external lines are a power-down line, three lines that can each be set to edge or level sensitivity, two level-only lines and one edge-only line. Edge-type and event-type sources are held in pending latches. Software can set or clear these latches, and each one is gated by a per-source enable mask. The power-down source ignores the mask.

The controller presents a registered request strobe, the vector address of the chosen source and its index. The core answers with a one-cycle acknowledge, which takes the presented source into service, and later with a return pulse, which retires the highest-priority source in service. A configuration word turns nesting on or off. A global enable, set at reset, can shut off all servicing. A write to the mask register holds the request strobe low for two cycles. The two lowest-priority serial-port positions can instead take their requests from two external lines when a mode input is set.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the request output is low, every mask bit is 0, nesting is off, the three configurable lines are level-sensitive and global servicing is enabled.
- R2: Source index sets priority, with 0 highest: 0 power-down, 1 IRQ2, 2 level line 1, 3 level line 0, 4 port-0 transmit, 5 port-0 receive, 6 edge line, 7 block transfer, 8 port-1 transmit or IRQ1, 9 port-1 receive or IRQ0, 10 timer. The vector is 0x002C for index 0 and 4×index for every other index. The lowest eligible index is presented.
- R3: A source can be presented only while its mask bit (bit i for index i) is 1. Mask bit 0 has no effect, so power-down is never masked. A masked edge or event source keeps its pending latch.
- R4: In the two cycles after the clock edge that samples a mask write, the request output is low. After that the new mask applies.
- R5: Disable clears and enable sets global servicing, and disable wins if both are asserted. While servicing is off, no source is presented, power-down included. A disable also forces the request low from the next cycle.
- R6: Each of IRQ2, IRQ1 and IRQ0 has an edge-mode bit. In edge mode, a falling edge of the synchronized line sets the pending latch. In level mode, the request follows the synchronized line (low = asserted) and no latch is kept. The synchronizer has two stages.
- R7: The edge line is always edge-triggered. The two level lines are always level-sensitive.
- R8: A force/clear write sets pending latches where its set bits are 1 and clears them where its clear bits are 1. Clear wins over set. Force has no effect on a source that is currently level-sensitive.
- R9: An acknowledge while the request is high clears the presented source's pending latch and marks that source in service. The request is low in the following cycle.
- R10: With nesting off, no source is presented while any source is in service.
- R11: With nesting on, a source is presented only when its index is lower than every index in service.
- R12: A return pulse removes the lowest index from the in-service set.
- R13: When the port-1 mode input is 0, indices 8 and 9 take their requests from the port-1 transmit and receive events. When it is 1, they take them from the IRQ1 and IRQ0 lines, and the port-1 events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwd_n | input | 1 | Power-down line, active low, edge |
| irq2_n | input | 1 | Configurable line for index 1 |
| irq1_n | input | 1 | Configurable line for index 8 in external mode |
| irq0_n | input | 1 | Configurable line for index 9 in external mode |
| irql1_n | input | 1 | Level line, index 2 |
| irql0_n | input | 1 | Level line, index 3 |
| irqe_n | input | 1 | Edge line, index 6 |
| sp0_tx_evt | input | 1 | Port-0 transmit event pulse |
| sp0_rx_evt | input | 1 | Port-0 receive event pulse |
| dma_evt | input | 1 | Block-transfer event pulse |
| sp1_tx_evt | input | 1 | Port-1 transmit event pulse |
| sp1_rx_evt | input | 1 | Port-1 receive event pulse |
| timer_evt | input | 1 | Timer event pulse |
| sp1_ext_mode | input | 1 | 1 selects external lines for indices 8 and 9 |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 11 | New mask, bit i enables index i |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_nest | input | 1 | Nesting enable |
| cfg_irq2_edge | input | 1 | IRQ2 edge mode |
| cfg_irq1_edge | input | 1 | IRQ1 edge mode |
| cfg_irq0_edge | input | 1 | IRQ0 edge mode |
| fc_we | input | 1 | Force/clear write strobe |
| fc_set | input | 11 | Latches to force |
| fc_clr | input | 11 | Latches to clear |
| int_ena | input | 1 | Global enable pulse |
| int_dis | input | 1 | Global disable pulse |
| core_ack | input | 1 | Core takes the presented source |
| core_rti | input | 1 | Core returns from a handler |
| irq_req | output | 1 | Registered request strobe |
| irq_vec | output | 14 | Vector address of the presented source |
| irq_src | output | 4 | Index of the presented source |

## Verification
The assertions assume that the core acknowledges only while the request is high and that it never raises acknowledge and return in the same cycle. They also assume that the return check applies only when something is in service. The stimulus respects these rules. Directed phases raise acknowledge only after seeing the strobe, and issue returns as separate pulses. The random phase draws acknowledges from the observed strobe and returns from the reference model's in-service set, and keeps the two apart. External lines change only at the falling clock edge, so the two-stage synchronizer latency is fixed and the reference model can follow it.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC  = 11;
  localparam int SRC_W = $clog2(NSRC);
  localparam int NLINE = 7;

  // source indices, order is priority (0 highest)
  localparam int S_PWD   = 0;
  localparam int S_IRQ2  = 1;
  localparam int S_IRQL1 = 2;
  localparam int S_IRQL0 = 3;
  localparam int S_SP0TX = 4;
  localparam int S_SP0RX = 5;
  localparam int S_IRQE  = 6;
  localparam int S_DMA   = 7;
  localparam int S_SP1TX = 8;
  localparam int S_SP1RX = 9;
  localparam int S_TIMER = 10;

  // external line slots
  localparam int L_PWD   = 0;
  localparam int L_IRQ2  = 1;
  localparam int L_IRQL1 = 2;
  localparam int L_IRQL0 = 3;
  localparam int L_IRQE  = 4;
  localparam int L_IRQ1  = 5;
  localparam int L_IRQ0  = 6;

  typedef struct packed {
    logic nest;
    logic irq2_edge;
    logic irq1_edge;
    logic irq0_edge;
  } intc_cfg_t;

  function automatic logic [15:0] vec_addr(input int idx);
    if (idx == S_PWD) return 16'h002C;
    return 16'(idx * 4);
  endfunction
endpackage

// File: rtl/intc_line_sync.sv
module intc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic active,
  output logic fell
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_n};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign active = ~chain_q[STAGES-1];
  assign fell   = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] keep_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) pend_o[g] <= 1'b0;
      else     pend_o[g] <= (pend_o[g] | set_i[g]) & ~clr_i[g] & keep_i[g];
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int N   = 11,
  parameter int IDW = $clog2(N)
) (
  input  logic [N-1:0]   req_i,
  input  logic [N-1:0]   svc_i,
  input  logic           gie_i,
  input  logic           hold_i,
  input  logic           nest_i,
  output logic           valid_o,
  output logic [IDW-1:0] id_o
);
  logic           found, busy, allow;
  logic [IDW-1:0] cand, top;

  always_comb begin
    found = 1'b0;
    cand  = '0;
    busy  = 1'b0;
    top   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found = 1'b1;
        cand  = IDW'(i);
      end
      if (svc_i[i]) begin
        busy = 1'b1;
        top  = IDW'(i);
      end
    end
    allow   = nest_i ? (!busy || (cand < top)) : !busy;
    valid_o = found && gie_i && !hold_i && allow;
    id_o    = cand;
  end
endmodule

// File: rtl/intc_svc_track.sv
module intc_svc_track #(
  parameter int N   = 11,
  parameter int IDW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           take_i,
  input  logic [IDW-1:0] take_id_i,
  input  logic           ret_i,
  output logic [N-1:0]   svc_o
);
  logic [N-1:0] lowbit, nxt;

  always_comb begin
    lowbit = svc_o & (~svc_o + N'(1));
    nxt    = ret_i ? (svc_o & ~lowbit) : svc_o;
    if (take_i) nxt[take_id_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) svc_o <= '0;
    else     svc_o <= nxt;
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int VEC_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwd_n,
  input  logic             irq2_n,
  input  logic             irq1_n,
  input  logic             irq0_n,
  input  logic             irql1_n,
  input  logic             irql0_n,
  input  logic             irqe_n,
  input  logic             sp0_tx_evt,
  input  logic             sp0_rx_evt,
  input  logic             dma_evt,
  input  logic             sp1_tx_evt,
  input  logic             sp1_rx_evt,
  input  logic             timer_evt,
  input  logic             sp1_ext_mode,
  input  logic             mask_we,
  input  logic [NSRC-1:0]  mask_wdata,
  input  logic             cfg_we,
  input  logic             cfg_nest,
  input  logic             cfg_irq2_edge,
  input  logic             cfg_irq1_edge,
  input  logic             cfg_irq0_edge,
  input  logic             fc_we,
  input  logic [NSRC-1:0]  fc_set,
  input  logic [NSRC-1:0]  fc_clr,
  input  logic             int_ena,
  input  logic             int_dis,
  input  logic             core_ack,
  input  logic             core_rti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [SRC_W-1:0] irq_src
);
  logic [NLINE-1:0] line_n, line_act, line_fell;
  logic [NSRC-1:0]  mask_q, pend_q, svc_q;
  logic [NSRC-1:0]  keep, setv, lvl, raw_req, eff_req, set_all, clr_all;
  intc_cfg_t        cfg_q;
  logic             gie_q, blk_q, req_q, req_d, take;
  logic [SRC_W-1:0] id_q, sel_id;
  logic [VEC_W-1:0] vec_q;
  logic             sel_valid;

  assign line_n = {irq0_n, irq1_n, irqe_n, irql0_n, irql1_n, irq2_n, pwd_n};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    intc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .pin_n  (line_n[g]),
      .active (line_act[g]),
      .fell   (line_fell[g])
    );
  end

  // source routing: which sources latch, what sets them, level values
  always_comb begin
    keep           = '1;
    keep[S_IRQL1]  = 1'b0;
    keep[S_IRQL0]  = 1'b0;
    keep[S_IRQ2]   = cfg_q.irq2_edge;
    keep[S_SP1TX]  = sp1_ext_mode ? cfg_q.irq1_edge : 1'b1;
    keep[S_SP1RX]  = sp1_ext_mode ? cfg_q.irq0_edge : 1'b1;

    setv           = '0;
    setv[S_PWD]    = line_fell[L_PWD];
    setv[S_IRQ2]   = line_fell[L_IRQ2];
    setv[S_SP0TX]  = sp0_tx_evt;
    setv[S_SP0RX]  = sp0_rx_evt;
    setv[S_IRQE]   = line_fell[L_IRQE];
    setv[S_DMA]    = dma_evt;
    setv[S_SP1TX]  = sp1_ext_mode ? line_fell[L_IRQ1] : sp1_tx_evt;
    setv[S_SP1RX]  = sp1_ext_mode ? line_fell[L_IRQ0] : sp1_rx_evt;
    setv[S_TIMER]  = timer_evt;

    lvl            = '0;
    lvl[S_IRQ2]    = line_act[L_IRQ2];
    lvl[S_IRQL1]   = line_act[L_IRQL1];
    lvl[S_IRQL0]   = line_act[L_IRQL0];
    lvl[S_SP1TX]   = sp1_ext_mode & line_act[L_IRQ1];
    lvl[S_SP1RX]   = sp1_ext_mode & line_act[L_IRQ0];

    raw_req = (pend_q & keep) | (lvl & ~keep);
    eff_req = raw_req & (mask_q | NSRC'(1));
  end

  assign take    = core_ack & req_q;
  assign set_all = setv | (fc_we ? fc_set : '0);

  always_comb begin
    clr_all = fc_we ? fc_clr : '0;
    if (take) clr_all[id_q] = 1'b1;
  end

  intc_pending #(.N(NSRC)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_all),
    .clr_i  (clr_all),
    .keep_i (keep),
    .pend_o (pend_q)
  );

  intc_svc_track #(.N(NSRC), .IDW(SRC_W)) u_svc (
    .clk       (clk),
    .rst       (rst),
    .take_i    (take),
    .take_id_i (id_q),
    .ret_i     (core_rti),
    .svc_o     (svc_q)
  );

  intc_arbiter #(.N(NSRC), .IDW(SRC_W)) u_arb (
    .req_i   (eff_req),
    .svc_i   (svc_q),
    .gie_i   (gie_q),
    .hold_i  (blk_q),
    .nest_i  (cfg_q.nest),
    .valid_o (sel_valid),
    .id_o    (sel_id)
  );

  assign req_d = sel_valid & ~mask_we & ~int_dis & ~take;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      cfg_q  <= '0;
      gie_q  <= 1'b1;
      blk_q  <= 1'b0;
      req_q  <= 1'b0;
      id_q   <= '0;
      vec_q  <= '0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      if (cfg_we)  cfg_q  <= '{nest: cfg_nest, irq2_edge: cfg_irq2_edge,
                               irq1_edge: cfg_irq1_edge, irq0_edge: cfg_irq0_edge};
      if (int_dis)      gie_q <= 1'b0;
      else if (int_ena) gie_q <= 1'b1;
      blk_q <= mask_we;
      req_q <= req_d;
      if (sel_valid) begin
        id_q  <= sel_id;
        vec_q <= VEC_W'(vec_addr(int'(sel_id)));
      end
    end
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;
  assign irq_src = id_q;
endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk #(
  parameter int N     = 11,
  parameter int VEC_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             mask_we,
  input logic             int_dis,
  input logic             core_ack,
  input logic             core_rti,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic [N-1:0]     svc
);
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec[1:0] == 2'b00 && irq_vec != '0 && irq_vec <= VEC_W'(44))); // R2
  AST_MASK_BLANK_FIRST: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> !irq_req); // R4
  AST_MASK_BLANK_SECOND: assert property (@(posedge clk) disable iff (rst)
    $past(mask_we) |=> !irq_req); // R4
  AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (rst)
    int_dis |=> !irq_req); // R5
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    (core_ack && irq_req) |=> !irq_req); // R9
  AST_ACK_IN_SERVICE: assert property (@(posedge clk) disable iff (rst)
    (core_ack && irq_req) |=> (svc != '0)); // R9
  AST_RTI_POPS_ONE: assert property (@(posedge clk) disable iff (rst)
    (core_rti && !(core_ack && irq_req) && svc != '0)
      |=> ($countones(svc) == $past($countones(svc)) - 1)); // R12
endmodule

bind prio_vec_intc prio_vec_intc_chk #(.N(intc_pkg::NSRC), .VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mask_we  (mask_we),
  .int_dis  (int_dis),
  .core_ack (core_ack),
  .core_rti (core_rti),
  .irq_req  (irq_req),
  .irq_vec  (irq_vec),
  .svc      (svc_q)
);

// File: tb/test_prio_vec_intc.sv
module test_prio_vec_intc;
  localparam int N = 11;
  localparam int VW = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwd_n = 1, irq2_n = 1, irq1_n = 1, irq0_n = 1, irql1_n = 1, irql0_n = 1, irqe_n = 1;
  logic sp0_tx_evt = 0, sp0_rx_evt = 0, dma_evt = 0, sp1_tx_evt = 0, sp1_rx_evt = 0, timer_evt = 0;
  logic sp1_ext_mode = 0;
  logic mask_we = 0, cfg_we = 0, fc_we = 0, int_ena = 0, int_dis = 0, core_ack = 0, core_rti = 0;
  logic [N-1:0] mask_wdata = '0, fc_set = '0, fc_clr = '0;
  logic cfg_nest = 0, cfg_irq2_edge = 0, cfg_irq1_edge = 0, cfg_irq0_edge = 0;
  logic irq_req;
  logic [VW-1:0] irq_vec;
  logic [3:0] irq_src;

  prio_vec_intc i_prio_vec_intc (
    .clk(clk), .rst(rst), .pwd_n(pwd_n), .irq2_n(irq2_n), .irq1_n(irq1_n), .irq0_n(irq0_n),
    .irql1_n(irql1_n), .irql0_n(irql0_n), .irqe_n(irqe_n),
    .sp0_tx_evt(sp0_tx_evt), .sp0_rx_evt(sp0_rx_evt), .dma_evt(dma_evt),
    .sp1_tx_evt(sp1_tx_evt), .sp1_rx_evt(sp1_rx_evt), .timer_evt(timer_evt),
    .sp1_ext_mode(sp1_ext_mode), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .cfg_we(cfg_we), .cfg_nest(cfg_nest), .cfg_irq2_edge(cfg_irq2_edge),
    .cfg_irq1_edge(cfg_irq1_edge), .cfg_irq0_edge(cfg_irq0_edge),
    .fc_we(fc_we), .fc_set(fc_set), .fc_clr(fc_clr), .int_ena(int_ena), .int_dis(int_dis),
    .core_ack(core_ack), .core_rti(core_rti),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_src(irq_src)
  );

  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  string phase = "R1";

  // ---------------- reference model ----------------
  bit hist[7][3];
  bit mp[N], ms[N], mm[N];
  bit mnest, me2, me1, me0, mgie, mblk, mreq;
  int mid;

  function automatic int exp_vec(int idx);
    return (idx == 0) ? 'h2C : idx * 4;
  endfunction

  function automatic bit model_busy();
    for (int i = 0; i < N; i++) if (ms[i]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin : model
    bit lv[7], fl[7], cur[7];
    bit lat[N], st[N], rq[N];
    int cand, top;
    bit ok, acked;
    if (rst) begin
      for (int l = 0; l < 7; l++) for (int k = 0; k < 3; k++) hist[l][k] = 1'b1;
      for (int i = 0; i < N; i++) begin mp[i] = 0; ms[i] = 0; mm[i] = 0; end
      mnest = 0; me2 = 0; me1 = 0; me0 = 0; mgie = 1; mblk = 0; mreq = 0; mid = 0;
    end else begin
      cur = '{pwd_n, irq2_n, irql1_n, irql0_n, irqe_n, irq1_n, irq0_n};
      for (int l = 0; l < 7; l++) begin
        lv[l] = (hist[l][1] == 0);
        fl[l] = (hist[l][1] == 0) && (hist[l][2] == 1);
      end
      for (int i = 0; i < N; i++) begin lat[i] = 1; st[i] = 0; end
      lat[2] = 0; lat[3] = 0; lat[1] = me2;
      lat[8] = sp1_ext_mode ? me1 : 1'b1;
      lat[9] = sp1_ext_mode ? me0 : 1'b1;
      st[0] = fl[0]; st[1] = fl[1]; st[4] = sp0_tx_evt; st[5] = sp0_rx_evt;
      st[6] = fl[4]; st[7] = dma_evt; st[10] = timer_evt;
      st[8] = sp1_ext_mode ? fl[5] : sp1_tx_evt;
      st[9] = sp1_ext_mode ? fl[6] : sp1_rx_evt;
      for (int i = 0; i < N; i++) rq[i] = lat[i] ? mp[i] : 1'b0;
      if (!lat[1]) rq[1] = lv[1];
      rq[2] = lv[2]; rq[3] = lv[3];
      if (!lat[8]) rq[8] = sp1_ext_mode && lv[5];
      if (!lat[9]) rq[9] = sp1_ext_mode && lv[6];
      cand = -1; top = 99;
      for (int i = N - 1; i >= 0; i--) begin
        if (rq[i] && (i == 0 || mm[i])) cand = i;
        if (ms[i]) top = i;
      end
      ok = (cand >= 0) && mgie && !mblk && (mnest ? (top == 99 || cand < top) : (top == 99));
      acked = core_ack && mreq;
      for (int i = 0; i < N; i++)
        mp[i] = (mp[i] | st[i] | (fc_we & fc_set[i])) & !(fc_we & fc_clr[i])
                & !(acked && mid == i) & lat[i];
      if (core_rti && top != 99) ms[top] = 0;
      if (acked) ms[mid] = 1;
      mreq = ok && !mask_we && !int_dis && !acked;
      if (ok) mid = cand;
      if (mask_we) for (int i = 0; i < N; i++) mm[i] = mask_wdata[i];
      if (cfg_we) begin mnest = cfg_nest; me2 = cfg_irq2_edge; me1 = cfg_irq1_edge; me0 = cfg_irq0_edge; end
      if (int_dis) mgie = 0; else if (int_ena) mgie = 1;
      mblk = mask_we;
      for (int l = 0; l < 7; l++) begin
        hist[l][2] = hist[l][1]; hist[l][1] = hist[l][0]; hist[l][0] = cur[l];
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst) begin
      n_cmp++;
      if (irq_req !== mreq) begin
        n_bad++;
        $display("FAIL %s: irq_req actual %0b expected %0b at cycle %0d", phase, irq_req, mreq, cycles);
      end else if (mreq && irq_vec !== VW'(exp_vec(mid))) begin
        n_bad++;
        $display("FAIL %s: irq_vec actual %h expected %h at cycle %0d", phase, irq_vec, exp_vec(mid), cycles);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_vec(string tag, int exp);
    chk({tag, " req"}, int'(irq_req), 1);
    chk({tag, " vec"}, int'(irq_vec), exp);
  endtask

  task automatic step();
    @(negedge clk);
    mask_we = 0; cfg_we = 0; fc_we = 0; int_ena = 0; int_dis = 0; core_ack = 0; core_rti = 0;
    sp0_tx_evt = 0; sp0_rx_evt = 0; dma_evt = 0; sp1_tx_evt = 0; sp1_rx_evt = 0; timer_evt = 0;
  endtask

  task automatic steps(int n);
    repeat (n) step();
  endtask

  task automatic write_mask(logic [N-1:0] m);
    step(); mask_we = 1; mask_wdata = m;
  endtask

  task automatic write_cfg(bit n, bit e2, bit e1, bit e0);
    step(); cfg_we = 1; cfg_nest = n; cfg_irq2_edge = e2; cfg_irq1_edge = e1; cfg_irq0_edge = e0;
  endtask

  task automatic force_clear(logic [N-1:0] s, logic [N-1:0] c);
    step(); fc_we = 1; fc_set = s; fc_clr = c;
  endtask

  task automatic ack_now();
    step(); core_ack = irq_req;
  endtask

  task automatic rti_now();
    step(); core_rti = 1;
  endtask

  task automatic drain();
    int quiet = 0;
    pwd_n = 1; irq2_n = 1; irq1_n = 1; irq0_n = 1; irql1_n = 1; irql0_n = 1; irqe_n = 1;
    force_clear('0, '1);
    for (int k = 0; k < 300 && quiet < 8; k++) begin
      step();
      if (irq_req) begin core_ack = 1; quiet = 0; end
      else if (model_busy()) begin core_rti = 1; quiet = 0; end
      else quiet++;
      if (k % 4 == 0) begin fc_we = 1; fc_set = '0; fc_clr = '1; end
    end
    step();
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    steps(3);
    rst = 0;
    phase = "R1";
    steps(3);
    chk("R1 reset req", int'(irq_req), 0);

    phase = "R3";
    step(); timer_evt = 1;
    steps(4);
    chk("R3 masked timer held", int'(irq_req), 0);
    step(); pwd_n = 0;
    steps(3); pwd_n = 1;
    steps(2);
    chk_vec("R3 power-down unmaskable", 'h2C);
    ack_now(); step();
    rti_now(); step();

    phase = "R4";
    write_mask('1);
    step();
    chk("R4 blank first", int'(irq_req), 0);
    step();
    chk("R4 blank second", int'(irq_req), 0);
    step();
    chk_vec("R4 new mask timer", 'h28);

    phase = "R2";
    step(); sp0_tx_evt = 1;
    steps(3);
    chk_vec("R2 higher source wins", 'h10);

    phase = "R9";
    ack_now();
    step();
    chk("R9 req low after ack", int'(irq_req), 0);
    phase = "R10";
    steps(3);
    chk("R10 no nest blocks timer", int'(irq_req), 0);
    phase = "R12";
    rti_now();
    steps(2);
    chk_vec("R12 timer after return", 'h28);

    phase = "R11";
    write_cfg(1, 0, 0, 0);
    step();
    ack_now(); step();
    step(); dma_evt = 1;
    steps(3);
    chk_vec("R11 higher preempts", 'h1C);
    ack_now(); step();
    step(); timer_evt = 1;
    steps(3);
    chk("R11 lower blocked", int'(irq_req), 0);
    drain();

    phase = "R6";
    write_cfg(0, 0, 0, 0);
    step(); irq2_n = 0;
    steps(4);
    chk_vec("R6 level follows line", 'h04);
    irq2_n = 1;
    steps(4);
    chk("R6 level release", int'(irq_req), 0);
    write_cfg(0, 1, 0, 0);
    step(); irq2_n = 0;
    step(); irq2_n = 1;
    steps(4);
    chk_vec("R6 edge latched", 'h04);
    drain();

    phase = "R7";
    step(); irqe_n = 0;
    step(); irqe_n = 1;
    steps(4);
    chk_vec("R7 edge line latched", 'h18);
    drain();
    step(); irql0_n = 0;
    steps(4);
    chk_vec("R7 level line", 'h0C);
    irql0_n = 1;
    steps(4);
    chk("R7 level line release", int'(irq_req), 0);

    phase = "R8";
    force_clear(11'b000_0000_1000, '0);
    steps(3);
    chk("R8 force on level source ignored", int'(irq_req), 0);
    force_clear(11'b000_1000_0000, '0);
    steps(3);
    chk_vec("R8 force sets", 'h1C);
    force_clear('0, 11'b000_1000_0000);
    steps(3);
    chk("R8 clear removes", int'(irq_req), 0);
    force_clear(11'b000_1000_0000, 11'b000_1000_0000);
    steps(3);
    chk("R8 clear beats set", int'(irq_req), 0);

    phase = "R5";
    force_clear(11'b100_0000_0000, '0);
    steps(3);
    chk_vec("R5 before disable", 'h28);
    step(); int_dis = 1;
    step();
    chk("R5 disable drops req", int'(irq_req), 0);
    step(); pwd_n = 0;
    steps(3); pwd_n = 1;
    steps(2);
    chk("R5 power-down gated", int'(irq_req), 0);
    step(); int_ena = 1; int_dis = 1;
    steps(3);
    chk("R5 disable wins", int'(irq_req), 0);
    step(); int_ena = 1;
    steps(3);
    chk_vec("R5 enable restores", 'h2C);
    drain();

    phase = "R13";
    step(); sp1_tx_evt = 1;
    steps(3);
    chk_vec("R13 port event", 'h20);
    drain();
    sp1_ext_mode = 1;
    step(); irq1_n = 0;
    steps(4);
    chk_vec("R13 external line", 'h20);
    irq1_n = 1;
    steps(4);
    step(); sp1_rx_evt = 1;
    steps(3);
    chk("R13 port event ignored", int'(irq_req), 0);
    drain();
    sp1_ext_mode = 0;

    phase = "RND";
    for (int k = 0; k < 4000; k++) begin
      step();
      if ($urandom_range(0, 7) == 0) pwd_n = ~pwd_n;
      if ($urandom_range(0, 5) == 0) irq2_n = ~irq2_n;
      if ($urandom_range(0, 5) == 0) irq1_n = ~irq1_n;
      if ($urandom_range(0, 5) == 0) irq0_n = ~irq0_n;
      if ($urandom_range(0, 9) == 0) irql1_n = ~irql1_n;
      if ($urandom_range(0, 9) == 0) irql0_n = ~irql0_n;
      if ($urandom_range(0, 5) == 0) irqe_n = ~irqe_n;
      sp0_tx_evt = ($urandom_range(0, 15) == 0);
      sp0_rx_evt = ($urandom_range(0, 15) == 0);
      dma_evt    = ($urandom_range(0, 15) == 0);
      sp1_tx_evt = ($urandom_range(0, 15) == 0);
      sp1_rx_evt = ($urandom_range(0, 15) == 0);
      timer_evt  = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 99) == 0) sp1_ext_mode = ~sp1_ext_mode;
      if ($urandom_range(0, 40) == 0) begin mask_we = 1; mask_wdata = N'($urandom); end
      if ($urandom_range(0, 60) == 0) begin
        cfg_we = 1; cfg_nest = $urandom_range(0, 1); cfg_irq2_edge = $urandom_range(0, 1);
        cfg_irq1_edge = $urandom_range(0, 1); cfg_irq0_edge = $urandom_range(0, 1);
      end
      if ($urandom_range(0, 30) == 0) begin fc_we = 1; fc_set = N'($urandom); fc_clr = N'($urandom); end
      if ($urandom_range(0, 50) == 0) int_dis = 1;
      if ($urandom_range(0, 20) == 0) int_ena = 1;
      if (irq_req && $urandom_range(0, 2) == 0) core_ack = 1;
      else if (model_busy() && $urandom_range(0, 5) == 0) core_rti = 1;
    end
    step(); int_ena = 1;
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule